// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave with Sync-Change Interrupt

This block lets a host read and write a small byte-wide configuration register file over a two-wire serial bus. It answers one 7-bit device address. The upper six bits of that address are fixed at `100110`, and the lowest bit comes from a board strap input. A write transaction works as follows. The first byte after the address loads an internal register pointer. Every byte after that is stored at the pointer, and the pointer then advances. A read transaction returns bytes starting at the pointer, and the pointer advances after every byte. The host normally sets the pointer with a short write, then issues a repeated START and the read address.

Both bus lines are sampled with the fast reference clock. SCL must hold a new level for three consecutive reference clocks before the slave accepts it, so short spikes are removed. SDA is delayed by the same number of stages so the two lines stay aligned. The bit engine is a state machine with seven states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_RX`: shifts in a written byte.
- `ST_RX_ACK`: acknowledges a written byte.
- `ST_TX`: shifts out a read byte.
- `ST_TX_ACK`: samples the master's acknowledge.

The transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, and to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_RX` for a write and to `ST_TX` for a read.
- `ST_RX` goes to `ST_RX_ACK` after eight bits, and `ST_RX_ACK` returns to `ST_RX`.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` returns to `ST_TX` on an ACK and goes to `ST_IDLE` on a NACK.

Each video channel supplies an activity level and a polarity level. When either level of a channel changes, that channel's bit in the interrupt status register is set. Writing a 1 to a status bit clears it. A mask register resets to all ones, which masks every source. The interrupt output is high whenever a set status bit has a mask bit of 0.

Top module: `twi_regfile_slave`

## Requirements
- R1: The slave acknowledges only the address byte `{6'b100110, addr_sel, rw}`, which is 0x98/0x99 with the strap low and 0x9A/0x9B with the strap high. For any other address it never drives SDA, and the bytes that follow change nothing.
- R2: An SCL pulse shorter than three reference clocks is ignored. It shifts no bit and does not corrupt the byte in progress.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R4: In a read, each byte returned is the register at the pointer, sent MSB first, and the pointer increments after each byte.
- R5: The slave pulls SDA low in the acknowledge slot of its own address and of every written byte, including bytes written to unimplemented addresses.
- R6: After the master NACKs a read byte, the slave releases SDA and stops driving until the next START.
- R7: Status bit i (address 0x04, bits 0..NCH-1) is set when the activity or the polarity input of channel i changes. Bits above NCH-1 read as 0.
- R8: Writing to the status register clears the bits written as 1 and leaves the bits written as 0 unchanged. Writing 0xFF clears all bits.
- R9: The mask register (address 0x05) resets to 0xFF. `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R10: A START or STOP seen in the middle of a byte abandons that byte without storing it. A START begins a new address phase at once.
- R11: After reset, SDA is released, `irq` is low, and every configuration register reads 0x00.
- R12: Reads of addresses at or above NREG return 0x00, and writes to those addresses are ignored. The configuration output slots for 0x04 and 0x05 always read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock used to sample both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that supplies the lowest device address bit |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| ch_active | input | NCH | Per-channel activity level |
| ch_polarity | input | NCH | Per-channel sync polarity level |
| cfg_q | output | NREG*8 | Configuration registers, byte k at bits 8k+7..8k |
| irq | output | 1 | Interrupt, high while an unmasked status bit is set |

## Verification
Register traffic is run as single-byte and multi-byte writes and as reads of one to three bytes. Seeing the same data return at rising pointers separates a correct auto-increment from a pointer that sticks or skips, and the range end at 0x0F/0x10 exposes address decoding faults. The same write is repeated with a narrow SCL spike placed inside a byte, and a different stored value would reveal a filter that lets the spike through. Writes to the status register with the patterns 0x02, 0x00 and 0xFF separate a correct write-one-to-clear from plain overwrite or no effect, and toggling the activity input of one channel and the polarity input of another checks the source-to-bit mapping. Address bytes that differ only in the strap bit, plus transactions cut short by a STOP or a START after a few bits, check that nothing is written when it should not be.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_pin_filter.sv
// Synchronises both bus lines, removes short SCL pulses and delays SDA
// by the same number of stages so the two stay aligned.
module twi_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_LEN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_f,
    output logic sda_f
);
    localparam int SDA_DLY = GLITCH_LEN + 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic [GLITCH_LEN-1:0]  scl_hist;
    logic [SDA_DLY-1:0]     sda_pipe;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];
    assign sda_f = sda_pipe[SDA_DLY-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_hist <= '1;
            sda_pipe <= '1;
            scl_f    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_pin};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_pin};
            scl_hist <= {scl_hist[GLITCH_LEN-2:0], scl_s};
            sda_pipe <= {sda_pipe[SDA_DLY-2:0], sda_s};
            if (scl_hist == '1) begin
                scl_f <= 1'b1;
            end else if (scl_hist == '0) begin
                scl_f <= 1'b0;
            end
        end
    end

    // Filtered SCL moves only after three consecutive agreeing samples.
    assert_scl_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_f) |-> ($past(scl_s, 2) == scl_f && $past(scl_s, 3) == scl_f
                             && $past(scl_s, 4) == scl_f));

endmodule

// File: rtl/twi_sync_watch.sv
// Flags a change of either activity or polarity on each channel.
module twi_sync_watch #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] act,
    input  logic [NCH-1:0] pol,
    output logic [NCH-1:0] chg
);
    logic [NCH-1:0] act_q;
    logic [NCH-1:0] pol_q;
    logic           primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            pol_q  <= '0;
            primed <= 1'b0;
        end else begin
            act_q  <= act;
            pol_q  <= pol;
            primed <= 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign chg[c] = primed & ((act[c] ^ act_q[c]) | (pol[c] ^ pol_q[c]));
    end

endmodule

// File: rtl/twi_bit_engine.sv
// Bit-level protocol machine: START/STOP detection, byte shifting and
// acknowledge handling. Produces byte strobes toward the register file.
module twi_bit_engine
    import twi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic       wr_valid,
    output logic       wr_first,
    output logic [7:0] wr_data,
    output logic       rd_next,
    output logic       sda_oe
);
    twi_state_e state, state_nx;
    logic       scl_q, sda_q;
    logic [2:0] cnt, cnt_nx;
    logic [7:0] sh, sh_nx;
    logic       full, full_nx;
    logic       rw, rw_nx;
    logic       first, first_nx;
    logic       mack, mack_nx;
    logic       oe_nx;
    logic       rise, fall, start_c, stop_c;

    assign rise    = ~scl_q & scl_f;
    assign fall    = scl_q & ~scl_f;
    assign start_c = scl_q & scl_f & sda_q & ~sda_f;
    assign stop_c  = scl_q & scl_f & ~sda_q & sda_f;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            cnt    <= '0;
            sh     <= '0;
            full   <= 1'b0;
            rw     <= 1'b0;
            first  <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            state  <= state_nx;
            scl_q  <= scl_f;
            sda_q  <= sda_f;
            cnt    <= cnt_nx;
            sh     <= sh_nx;
            full   <= full_nx;
            rw     <= rw_nx;
            first  <= first_nx;
            mack   <= mack_nx;
            sda_oe <= oe_nx;
        end
    end

    // Next-state and output process
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        sh_nx    = sh;
        full_nx  = full;
        rw_nx    = rw;
        first_nx = first;
        mack_nx  = mack;
        oe_nx    = sda_oe;
        wr_valid = 1'b0;
        wr_first = first;
        wr_data  = sh;
        rd_next  = 1'b0;
        if (stop_c) begin
            state_nx = ST_IDLE;
            oe_nx    = 1'b0;
            full_nx  = 1'b0;
        end else if (start_c) begin
            state_nx = ST_ADDR;
            cnt_nx   = '0;
            full_nx  = 1'b0;
            oe_nx    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    oe_nx = 1'b0;
                end
                ST_ADDR: begin
                    if (rise) begin
                        sh_nx  = {sh[6:0], sda_f};
                        cnt_nx = cnt + 3'd1;
                        if (cnt == 3'd7) full_nx = 1'b1;
                    end else if (fall && full) begin
                        full_nx = 1'b0;
                        if (sh[7:1] == dev_addr) begin
                            state_nx = ST_ADDR_ACK;
                            rw_nx    = sh[0];
                            oe_nx    = 1'b1;
                        end else begin
                            state_nx = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall) begin
                        cnt_nx = '0;
                        if (rw) begin
                            state_nx = ST_TX;
                            sh_nx    = rd_data;
                            oe_nx    = ~rd_data[7];
                        end else begin
                            state_nx = ST_RX;
                            oe_nx    = 1'b0;
                            first_nx = 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (rise) begin
                        sh_nx  = {sh[6:0], sda_f};
                        cnt_nx = cnt + 3'd1;
                        if (cnt == 3'd7) full_nx = 1'b1;
                    end else if (fall && full) begin
                        full_nx  = 1'b0;
                        state_nx = ST_RX_ACK;
                        oe_nx    = 1'b1;
                        wr_valid = 1'b1;
                    end
                end
                ST_RX_ACK: begin
                    if (fall) begin
                        state_nx = ST_RX;
                        oe_nx    = 1'b0;
                        first_nx = 1'b0;
                        cnt_nx   = '0;
                    end
                end
                ST_TX: begin
                    if (fall) begin
                        if (cnt == 3'd7) begin
                            state_nx = ST_TX_ACK;
                            oe_nx    = 1'b0;
                        end else begin
                            cnt_nx = cnt + 3'd1;
                            sh_nx  = {sh[6:0], 1'b0};
                            oe_nx  = ~sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (rise) begin
                        mack_nx = ~sda_f;
                        rd_next = 1'b1;
                    end else if (fall) begin
                        if (mack) begin
                            state_nx = ST_TX;
                            sh_nx    = rd_data;
                            oe_nx    = ~rd_data[7];
                            cnt_nx   = '0;
                        end else begin
                            state_nx = ST_IDLE;
                            oe_nx    = 1'b0;
                        end
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    oe_nx    = 1'b0;
                end
            endcase
        end
    end

    // SDA is pulled only in acknowledge slots or while sending read data.
    assert_oe_in_drive_states_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_RX_ACK || state == ST_TX));

    // A STOP on the filtered lines always returns the machine to idle.
    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (state == ST_IDLE && !sda_oe));

    // Leaving the read acknowledge slot on a NACK releases the line.
    assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && fall && !mack && !start_c && !stop_c) |=> !sda_oe);

endmodule

// File: rtl/twi_reg_bank.sv
// Register pointer, configuration bytes, interrupt status and mask.
module twi_reg_bank #(
    parameter int         NREG      = 16,
    parameter int         NCH       = 4,
    parameter logic [7:0] STAT_ADDR = 8'h04,
    parameter logic [7:0] MASK_ADDR = 8'h05
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic            wr_first,
    input  logic [7:0]      wr_data,
    input  logic            rd_next,
    input  logic [NCH-1:0]  chg,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] cfg_q,
    output logic            irq
);
    localparam int         IW     = $clog2(NREG);
    localparam logic [8:0] NREG_W = 9'(NREG);

    logic [7:0]                ptr;
    logic [NCH-1:0]            stat;
    logic [7:0]                mask;
    logic [NREG-1:0][7:0]      cfg_arr;
    logic                      wr_byte, wr_stat, wr_mask, wr_cfg, in_range;
    logic [NCH-1:0]            clr;

    assign in_range = ({1'b0, ptr} < NREG_W);
    assign wr_byte  = wr_valid & ~wr_first;
    assign wr_stat  = wr_byte & (ptr == STAT_ADDR);
    assign wr_mask  = wr_byte & (ptr == MASK_ADDR);
    assign wr_cfg   = wr_byte & in_range & (ptr != STAT_ADDR) & (ptr != MASK_ADDR);
    assign clr      = wr_stat ? wr_data[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_valid && wr_first) begin
            ptr <= wr_data;
        end else if (wr_valid || rd_next) begin
            ptr <= ptr + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            mask <= 8'hFF;
        end else begin
            stat <= (stat & ~clr) | chg;
            if (wr_mask) mask <= wr_data;
        end
    end

    for (genvar a = 0; a < NREG; a++) begin : g_reg
        if (a == int'(STAT_ADDR) || a == int'(MASK_ADDR)) begin : g_hole
            assign cfg_arr[a] = '0;
        end else begin : g_cell
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_cfg && ptr == 8'(a)) begin
                    q <= wr_data;
                end
            end
            assign cfg_arr[a] = q;
        end
    end

    assign cfg_q = cfg_arr;

    always_comb begin
        if (ptr == STAT_ADDR) begin
            rd_data = 8'(stat);
        end else if (ptr == MASK_ADDR) begin
            rd_data = mask;
        end else if (in_range) begin
            rd_data = cfg_arr[ptr[IW-1:0]];
        end else begin
            rd_data = '0;
        end
    end

    assign irq = |(stat & ~mask[NCH-1:0]);

    // A channel event always leaves its status bit set.
    assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |=> ((stat & $past(chg)) == $past(chg)));

    // Bits written as 1 are clear afterwards unless a new event arrived.
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && chg == '0) |=> ((stat & $past(wr_data[NCH-1:0])) == '0));

    // An unmasked event raises the interrupt on the next cycle.
    assert_unmasked_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(chg & ~mask[NCH-1:0])) && !wr_mask) |=> irq);

    // Pointer never moves without a byte strobe.
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !rd_next) |=> $stable(ptr));

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
    parameter int         NREG        = 16,
    parameter int         NCH         = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         GLITCH_LEN  = 3,
    parameter logic [5:0] ADDR_HI     = 6'b100110,
    parameter logic [7:0] STAT_ADDR   = 8'h04,
    parameter logic [7:0] MASK_ADDR   = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [NCH-1:0]    ch_active,
    input  logic [NCH-1:0]    ch_polarity,
    output logic [NREG*8-1:0] cfg_q,
    output logic              irq
);
    logic           scl_f, sda_f;
    logic           wr_valid, wr_first, rd_next;
    logic [7:0]     wr_data, rd_data;
    logic [NCH-1:0] chg;

    twi_pin_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .GLITCH_LEN (GLITCH_LEN)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_pin(scl_i),
        .sda_pin(sda_i),
        .scl_f  (scl_f),
        .sda_f  (sda_f)
    );

    twi_bit_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .dev_addr({ADDR_HI, addr_sel}),
        .rd_data (rd_data),
        .wr_valid(wr_valid),
        .wr_first(wr_first),
        .wr_data (wr_data),
        .rd_next (rd_next),
        .sda_oe  (sda_oe)
    );

    twi_sync_watch #(
        .NCH(NCH)
    ) u_watch (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (ch_active),
        .pol  (ch_polarity),
        .chg  (chg)
    );

    twi_reg_bank #(
        .NREG     (NREG),
        .NCH      (NCH),
        .STAT_ADDR(STAT_ADDR),
        .MASK_ADDR(MASK_ADDR)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(wr_valid),
        .wr_first(wr_first),
        .wr_data (wr_data),
        .rd_next (rd_next),
        .chg     (chg),
        .rd_data (rd_data),
        .cfg_q   (cfg_q),
        .irq     (irq)
    );

endmodule

// File: tb/twi_regfile_slave_tb.sv
module twi_regfile_slave_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         addr_sel = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic [3:0]   ch_active = '0;
    logic [3:0]   ch_polarity = '0;
    logic [127:0] cfg_q;
    logic         irq;
    logic         sda_line;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] mdl_cfg [16];
    logic [7:0] mdl_stat = 8'h00;
    logic [7:0] mdl_mask = 8'hFF;

    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];
    logic [7:0] mon_e, mon_a;
    string      mon_t;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    twi_regfile_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel   (addr_sel),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .ch_active  (ch_active),
        .ch_polarity(ch_polarity),
        .cfg_q      (cfg_q),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each received read byte with the queued expectation
    always @(negedge clk) begin
        if (act_q.size() > 0 && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_a = act_q.pop_front();
            mon_t = tag_q.pop_front();
            n_checks++;
            if (mon_a !== mon_e) begin
                n_err++;
                $display("FAIL %s read byte: actual=%0h expected=%0h", mon_t, mon_a, mon_e);
            end
        end
    end

    function automatic logic [7:0] exp_reg(input logic [7:0] a);
        if (a == 8'h04) return mdl_stat;
        if (a == 8'h05) return mdl_mask;
        if (a < 8'd16)  return mdl_cfg[a[3:0]];
        return 8'h00;
    endfunction

    function automatic logic [7:0] dev_byte(input bit rd);
        return {6'b100110, addr_sel, rd};
    endfunction

    task automatic qtr();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qtr();
        scl_m = 1'b1; qtr();
        sda_m = 1'b0; qtr();
        scl_m = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr();
        scl_m = 1'b1; qtr();
        sda_m = 1'b1; qtr(); qtr();
    endtask

    task automatic raw_bits(input logic [7:0] b, input int nb, input bit glitch);
        for (int i = 7; i >= 8 - nb; i--) begin
            sda_m = b[i];
            if (glitch && i == 3) begin
                repeat (3) @(negedge clk);
                scl_m = 1'b1;
                repeat (2) @(negedge clk);
                scl_m = 1'b0;
                repeat (5) @(negedge clk);
            end else begin
                qtr();
            end
            scl_m = 1'b1; qtr(); qtr();
            scl_m = 1'b0; qtr();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        raw_bits(b, 8, glitch);
        sda_m = 1'b1; qtr();
        scl_m = 1'b1; qtr();
        ack = !sda_line;
        qtr();
        scl_m = 1'b0; qtr();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qtr();
            scl_m = 1'b1; qtr();
            b[i] = sda_line;
            qtr();
            scl_m = 1'b0; qtr();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; qtr();
        scl_m = 1'b1; qtr(); qtr();
        scl_m = 1'b0; qtr();
        sda_m = 1'b1;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h04)      mdl_stat = mdl_stat & ~d & 8'h0F;
        else if (a == 8'h05) mdl_mask = d;
        else if (a < 8'd16)  mdl_cfg[a[3:0]] = d;
    endtask

    task automatic check_cfg(input string tag);
        logic [127:0] e;
        for (int a = 0; a < 16; a++) e[a*8 +: 8] = (a == 4 || a == 5) ? 8'h00 : mdl_cfg[a];
        check(tag, cfg_q, e);
    endtask

    task automatic wr_txn(input logic [7:0] ptr, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n, input bit glitch, input string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, ack);
        check("R5 address ack", ack, 1);
        send_byte(ptr, 1'b0, ack);
        check("R5 pointer ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
            send_byte(d, glitch && i == 0, ack);
            check("R5 data ack", ack, 1);
            model_write(8'(ptr + 8'(i)), d);
        end
        bus_stop();
        check_cfg(tag);
    endtask

    task automatic rd_txn(input logic [7:0] ptr, input int n, input string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, ack);
        check("R5 address ack", ack, 1);
        send_byte(ptr, 1'b0, ack);
        check("R5 pointer ack", ack, 1);
        bus_start();
        send_byte(dev_byte(1'b1), 1'b0, ack);
        check("R5 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(exp_reg(8'(ptr + 8'(i))));
            tag_q.push_back(tag);
            recv_byte(i != n - 1, b);
            act_q.push_back(b);
        end
        check("R6 released after NACK", sda_oe, 0);
        qtr();
        check("R6 still released", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        for (int a = 0; a < 16; a++) mdl_cfg[a] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        check("R11 sda_oe", sda_oe, 0);
        check("R11 irq", irq, 0);
        check("R11 cfg_q", cfg_q, 0);

        // R9: mask reset value; status empty
        rd_txn(8'h05, 1, "R9 mask reset");
        rd_txn(8'h04, 1, "R7 status empty");

        // R3/R4: multi-byte write and read with auto-increment
        wr_txn(8'h00, 8'hA1, 8'hB2, 8'hC3, 3, 1'b0, "R3 burst write");
        rd_txn(8'h00, 3, "R4 burst read");
        wr_txn(8'h0B, 8'h6E, 8'h00, 8'h00, 1, 1'b0, "R3 single write");
        rd_txn(8'h01, 2, "R4 offset read");

        // R1: wrong strap address is not acknowledged and writes nothing
        bus_start();
        send_byte(8'h9A, 1'b0, ack);
        check("R1 foreign address nack", ack, 0);
        send_byte(8'h07, 1'b0, ack);
        check("R1 no ack after mismatch", ack, 0);
        send_byte(8'h5A, 1'b0, ack);
        bus_stop();
        check_cfg("R1 nothing written");

        // R1: with the strap high the other address answers
        addr_sel = 1'b1;
        wr_txn(8'h07, 8'h5A, 8'h00, 8'h00, 1, 1'b0, "R1 strap high write");
        rd_txn(8'h07, 1, "R1 strap high read");
        bus_start();
        send_byte(8'h98, 1'b0, ack);
        check("R1 low address ignored when strap high", ack, 0);
        bus_stop();
        addr_sel = 1'b0;

        // R2: narrow SCL spike inside a byte
        wr_txn(8'h03, 8'h96, 8'h00, 8'h00, 1, 1'b1, "R2 glitch write");
        rd_txn(8'h03, 1, "R2 glitch readback");

        // R12: out-of-range addresses
        wr_txn(8'h0E, 8'h11, 8'h22, 8'h33, 3, 1'b0, "R12 write past end");
        rd_txn(8'h0F, 2, "R12 read past end");

        // R10: STOP in the middle of a data byte
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, ack);
        send_byte(8'h08, 1'b0, ack);
        raw_bits(8'h77, 4, 1'b0);
        bus_stop();
        check_cfg("R10 stop mid byte");
        // R10: START in the middle of a data byte, then a fresh write
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, ack);
        send_byte(8'h08, 1'b0, ack);
        raw_bits(8'hE5, 3, 1'b0);
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, ack);
        check("R10 restart address ack", ack, 1);
        send_byte(8'h0A, 1'b0, ack);
        send_byte(8'h3C, 1'b0, ack);
        check("R10 restart data ack", ack, 1);
        model_write(8'h0A, 8'h3C);
        bus_stop();
        check_cfg("R10 restart write");

        // R7/R9: interrupt sources and masking
        ch_active[1] = 1'b1;
        repeat (5) @(negedge clk);
        mdl_stat = mdl_stat | 8'h02;
        check("R9 masked irq", irq, 0);
        rd_txn(8'h04, 1, "R7 activity change");
        wr_txn(8'h05, 8'hFD, 8'h00, 8'h00, 1, 1'b0, "R9 mask write");
        check("R9 unmasked irq", irq, 1);
        ch_polarity[2] = 1'b1;
        repeat (5) @(negedge clk);
        mdl_stat = mdl_stat | 8'h04;
        rd_txn(8'h04, 1, "R7 polarity change");

        // R8: write-one-to-clear
        wr_txn(8'h04, 8'h02, 8'h00, 8'h00, 1, 1'b0, "R8 clear bit1");
        check("R8 irq after clear", irq, 0);
        wr_txn(8'h04, 8'h00, 8'h00, 8'h00, 1, 1'b0, "R8 zero write");
        rd_txn(8'h04, 1, "R8 zero write keeps bits");
        wr_txn(8'h05, 8'hF8, 8'h00, 8'h00, 1, 1'b0, "R9 unmask bit2");
        check("R9 irq bit2", irq, 1);
        wr_txn(8'h04, 8'hFF, 8'h00, 8'h00, 1, 1'b0, "R8 clear all");
        check("R8 irq after clear all", irq, 0);
        rd_txn(8'h04, 2, "R8 status and mask readback");

        repeat (20) @(negedge clk);
        check("R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule